// File: doc/BRIEF.md
# Master-Clock Ratio Detector with Sample Resynchroniser

This block runs on the master system clock. It measures how many system-clock cycles fall between consecutive rising edges of the word clock. The word clock must already be synchronous to the system clock. The block sorts each measured period into one of three oversampling ratios: 256, 384 or 512 system clocks per sample. Once two measured frames in a row agree, it declares lock. From the detected ratio it derives a tick at 64 times the sample rate, which drives a downstream noise-shaping modulator. The tick divides the system clock by 4, 6 or 8, and its phase restarts at every word-clock rising edge.

While locked, the block tolerates word-clock edges that arrive near their expected position. An edge that arrives far too early or far too late counts as a phase slip. For an early edge, the block drops the next incoming sample. For a late edge, it asks the modulator to repeat the previous sample. If the slip persists for a second frame, the block does not act again. It drops lock and re-measures the ratio.

Every interface is a plain single-cycle strobe. There is no valid/ready handshake and no back-pressure. Each incoming sample strobe produces exactly one pass or drop decision. A repeat request is issued on its own, without any strobe.

Top module: `clk_ratio_sync`

## Requirements
- R1: After reset, `lock_o` is 0 and `ratio_o` is 0 (none). `os_tick_o`, `smp_pass_o`, `smp_drop_o` and `smp_rep_o` are all 0 until a ratio has been found. The `ratio_o` encoding is 0 = none, 1 = 256x, 2 = 384x, 3 = 512x.
- R2: A measured period is classified as a ratio when it lies within ±2 cycles of 256, 384 or 512. For example, 254 and 258 classify as 256x, while 259 matches no ratio.
- R3: While unlocked, two consecutive measured periods with the same valid class set `lock_o` to 1 and load that class into `ratio_o`. The first rising edge after reset, or after a word-clock loss, only starts a measurement.
- R4: While unlocked, a period that matches no ratio keeps `lock_o` at 0. `ratio_o` keeps its last valid value.
- R5: While `ratio_o` is non-zero, `os_tick_o` pulses for one cycle every N/64 system clocks, where N is the detected ratio. This gives 64 ticks in every steady frame of N cycles.
- R6: While locked, a period within N/4 of the detected ratio N keeps lock and produces no drop or repeat action.
- R7: While locked, a period shorter than N - N/4 is an early slip. The next sample strobe is answered with `smp_drop_o` instead of `smp_pass_o`.
- R8: While locked, a period longer than N + N/4 is a late slip. It produces one `smp_rep_o` pulse.
- R9: A second consecutive out-of-window period produces no further slip action. It clears `lock_o`, and this period becomes the first measurement towards a new lock.
- R10: Every `smp_stb_i` pulse is answered one cycle later by exactly one pulse on either `smp_pass_o` or `smp_drop_o`.
- R11: If no word-clock rising edge arrives before the period counter reaches its maximum (2047 cycles by default), `lock_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wclk_i | input | 1 | Word clock, already synchronous to clk_i |
| smp_stb_i | input | 1 | One-cycle strobe per incoming sample |
| ratio_o | output | 2 | Detected ratio: 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| lock_o | output | 1 | Ratio locked |
| os_tick_o | output | 1 | Oversampling tick at 64 times the sample rate |
| smp_pass_o | output | 1 | Forward the strobed sample |
| smp_drop_o | output | 1 | Discard the strobed sample (early slip) |
| smp_rep_o | output | 1 | Repeat the previous sample (late slip) |

## Verification
The hardest state to reach is the second consecutive out-of-window frame. Only here do the slip action and the lock loss separate. Getting there takes a locked ratio followed by two abnormal periods.

The stimulus first locks at 384x. It then switches to 512-cycle frames: the first 512-cycle frame must produce a single repeat, the second must drop lock, and the third must relock at 512x. Later, two 300-cycle frames are sent while locked at 512x. The first must cause one drop, and the second must unlock with the held ratio still showing 512x.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    RAT_NONE = 2'd0,
    RAT_256  = 2'd1,
    RAT_384  = 2'd2,
    RAT_512  = 2'd3
  } ratio_e;

  localparam int NOM_W = 10;

  function automatic logic [NOM_W-1:0] nominal_cycles(ratio_e r);
    case (r)
      RAT_256: return 10'd256;
      RAT_384: return 10'd384;
      RAT_512: return 10'd512;
      default: return 10'd0;
    endcase
  endfunction

  function automatic logic [3:0] tick_div(ratio_e r);
    case (r)
      RAT_384: return 4'd6;
      RAT_512: return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ratio_meas.sv
module ratio_meas
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rise_i,
  output ratio_e ratio_o,
  output logic   lock_o,
  output logic   slip_early_o,
  output logic   slip_late_o
);
  localparam int XW = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q, slipped_q;
  ratio_e           prev_q, cls;
  logic [XW-1:0]    meas, nom, quarter;
  logic             early, late, sat;

  assign meas    = {1'b0, cnt_q};
  assign nom     = XW'(nominal_cycles(ratio_o));
  assign quarter = nom >> 2;
  assign early   = meas < (nom - quarter);
  assign late    = meas > (nom + quarter);
  assign sat     = (cnt_q == CNT_MAX) && !rise_i;

  always_comb begin
    cls = RAT_NONE;
    for (int k = 1; k < 4; k++) begin
      if ((meas + XW'(TOL) >= XW'(nominal_cycles(ratio_e'(2'(k))))) &&
          (meas <= XW'(nominal_cycles(ratio_e'(2'(k)))) + XW'(TOL)))
        cls = ratio_e'(2'(k));
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen_q       <= 1'b0;
      slipped_q    <= 1'b0;
      lock_o       <= 1'b0;
      ratio_o      <= RAT_NONE;
      prev_q       <= RAT_NONE;
      slip_early_o <= 1'b0;
      slip_late_o  <= 1'b0;
    end else begin
      slip_early_o <= 1'b0;
      slip_late_o  <= 1'b0;
      if (sat) begin
        lock_o    <= 1'b0;
        seen_q    <= 1'b0;
        prev_q    <= RAT_NONE;
        slipped_q <= 1'b0;
      end else if (rise_i) begin
        seen_q <= 1'b1;
        if (seen_q) begin
          if (!lock_o) begin
            if (cls != RAT_NONE && cls == prev_q) begin
              lock_o  <= 1'b1;
              ratio_o <= cls;
            end
            prev_q <= cls;
          end else if (early || late) begin
            if (!slipped_q) begin
              slipped_q    <= 1'b1;
              slip_early_o <= early;
              slip_late_o  <= late;
            end else begin
              lock_o    <= 1'b0;
              slipped_q <= 1'b0;
              prev_q    <= cls;
            end
          end else begin
            slipped_q <= 1'b0;
          end
        end
      end
    end
  end

  assert_lock_has_ratio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (ratio_o != RAT_NONE));
  assert_lock_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(rise_i));
  assert_slip_one_dir_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slip_early_o && slip_late_o));
  assert_slip_while_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_early_o || slip_late_o) |-> lock_o);
endmodule

// File: rtl/os_tick_gen.sv
module os_tick_gen
  import clk_ratio_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rise_i,
  input  ratio_e ratio_i,
  output logic   tick_o
);
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last;

  assign last   = PH_W'(tick_div(ratio_i) - 4'd1);
  assign tick_o = (ratio_i != RAT_NONE) && (ph_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         ph_q <= '0;
    else if (rise_i)     ph_q <= '0;
    else if (ph_q >= last) ph_q <= '0;
    else                 ph_q <= ph_q + PH_W'(1);
  end

  assert_tick_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !rise_i) |=> !tick_o);
endmodule

// File: rtl/smp_resync.sv
module smp_resync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_stb_i,
  input  logic slip_early_i,
  input  logic slip_late_i,
  output logic pass_o,
  output logic drop_o,
  output logic rep_o
);
  logic pend_q, drop_now;

  assign drop_now = pend_q || slip_early_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pass_o <= 1'b0;
      drop_o <= 1'b0;
      rep_o  <= 1'b0;
    end else begin
      rep_o  <= slip_late_i;
      pass_o <= smp_stb_i && !drop_now;
      drop_o <= smp_stb_i && drop_now;
      pend_q <= drop_now && !smp_stb_i;
    end
  end

  assert_strobe_answered_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i |=> (pass_o ^ drop_o));
  assert_no_unasked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_stb_i |=> !(pass_o || drop_o));
endmodule

// File: rtl/clk_ratio_sync.sv
module clk_ratio_sync
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wclk_i,
  input  logic       smp_stb_i,
  output logic [1:0] ratio_o,
  output logic       lock_o,
  output logic       os_tick_o,
  output logic       smp_pass_o,
  output logic       smp_drop_o,
  output logic       smp_rep_o
);
  logic   wclk_q, rise, slip_e, slip_l;
  ratio_e ratio;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) wclk_q <= 1'b0;
    else         wclk_q <= wclk_i;
  end
  assign rise    = wclk_i && !wclk_q;
  assign ratio_o = ratio;

  ratio_meas #(.CNT_W(CNT_W), .TOL(TOL)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .ratio_o(ratio), .lock_o(lock_o),
    .slip_early_o(slip_e), .slip_late_o(slip_l)
  );

  os_tick_gen #(.PH_W(4)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .ratio_i(ratio), .tick_o(os_tick_o)
  );

  smp_resync u_resync (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_stb_i(smp_stb_i),
    .slip_early_i(slip_e), .slip_late_i(slip_l),
    .pass_o(smp_pass_o), .drop_o(smp_drop_o), .rep_o(smp_rep_o)
  );
endmodule

// File: tb/clk_ratio_sync_test.sv
module clk_ratio_sync_test;
  localparam int K_PASS = 0, K_DROP = 1, K_REP = 2;

  logic clk = 1'b0, rst_n = 1'b0, wclk = 1'b0, stb = 1'b0;
  logic [1:0] ratio;
  logic lock, tick, pass, drop, rep;
  int errors = 0, checks = 0, ticks = 0;
  bit done = 0;
  int q[$];

  always #5 clk = ~clk;

  clk_ratio_sync uut (
    .clk_i(clk), .rst_ni(rst_n), .wclk_i(wclk), .smp_stb_i(stb),
    .ratio_o(ratio), .lock_o(lock), .os_tick_o(tick),
    .smp_pass_o(pass), .smp_drop_o(drop), .smp_rep_o(rep)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One word-clock frame of p cycles; the sample strobe comes 10 cycles after the rise.
  task automatic frame(int p, int kind);
    ticks = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (tick) ticks++;
      wclk = (i < p / 2);
      stb  = (i == 10);
      if (i == 10) q.push_back(kind);
    end
  endtask

  // Scoreboard monitor: every decision pulse is compared with the expected queue.
  always @(negedge clk) begin
    if (rst_n && (pass || drop || rep)) begin
      int got;
      got = rep ? K_REP : (drop ? K_DROP : K_PASS);
      checks++;
      if ((pass + drop + rep) != 1) begin
        errors++;
        $display("FAIL R10: actual=%0d pulses expected=1", pass + drop + rep);
      end else if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: actual=decision %0d expected=none", got);
      end else begin
        int exp;
        exp = q.pop_front();
        if (got != exp) begin
          errors++;
          $display("FAIL R7/R8/R10: actual=decision %0d expected=%0d", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 lock", lock, 0);
    check("R1 ratio", ratio, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 lock", lock, 0);
    check("R1 ratio", ratio, 0);
    check("R1 tick", tick, 0);
    check("R1 decisions", pass + drop + rep, 0);

    // R3: lock at 384x after two agreeing periods
    frame(384, K_PASS);
    frame(384, K_PASS);
    check("R3 not yet locked", lock, 0);
    frame(384, K_PASS);
    check("R3 lock", lock, 1);
    check("R3 ratio 384", ratio, 2);
    frame(384, K_PASS);
    check("R5 ticks per 384 frame", ticks, 64);

    // R6: small phase deviations tolerated
    frame(434, K_PASS);
    frame(340, K_PASS);
    frame(384, K_PASS);
    check("R6 lock kept", lock, 1);
    check("R6 ratio kept", ratio, 2);

    // R7: early slip drops the next sample
    frame(250, K_PASS);
    frame(384, K_DROP);
    check("R7 lock kept", lock, 1);
    frame(384, K_PASS);

    // R8: late slip repeats once
    frame(500, K_PASS);
    q.push_back(K_REP);
    frame(384, K_PASS);
    frame(384, K_PASS);
    check("R8 lock kept", lock, 1);

    // R9: ratio change to 512x
    frame(512, K_PASS);
    q.push_back(K_REP);
    frame(512, K_PASS);
    check("R9 lock kept after first slip", lock, 1);
    frame(512, K_PASS);
    check("R9 lock lost", lock, 0);
    frame(512, K_PASS);
    check("R9 relock", lock, 1);
    check("R9 ratio 512", ratio, 3);
    frame(512, K_PASS);
    check("R5 ticks per 512 frame", ticks, 64);

    // R4 / R2: unmatched periods
    frame(300, K_PASS);
    frame(300, K_DROP);
    frame(259, K_PASS);
    check("R4 lock cleared", lock, 0);
    check("R4 ratio held", ratio, 3);
    frame(259, K_PASS);
    frame(254, K_PASS);
    check("R2 259 does not lock", lock, 0);
    frame(258, K_PASS);
    frame(256, K_PASS);
    check("R2 254/258 lock", lock, 1);
    check("R2 ratio 256", ratio, 1);
    frame(256, K_PASS);
    check("R5 ticks per 256 frame", ticks, 64);

    // R11: word clock stops
    repeat (2100) @(negedge clk);
    check("R11 lock lost", lock, 0);
    check("R10 queue drained", q.size(), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule